// File: doc/BRIEF.md
# Serial Memory Sector-Erase Command Engine

This block is the slave-side command logic of a serial nonvolatile memory model, built around sector erase. It watches chip select, serial clock and serial data in, samples data on each rising serial clock while chip select is low, and decodes an 8-bit opcode followed by a 24-bit address. It keeps a small status byte with a busy flag, a write-enable latch and a two-bit protection field. It also answers status-read commands on its serial output.

An erase only goes ahead when three things hold. A write-enable command was sent as its own transaction before it. Chip select went high exactly after the 32nd bit. The target sector is outside the protected region. The erase is self-timed over a parameterised number of system clocks, and then every byte of the addressed quarter of the array reads all ones. The array is a small behavioural register file, reset to a known pattern, with a side read port. The protection field is loaded from a parallel port.

Top module: `spi_sector_erase_engine`

## Requirements
- R1: After reset the status byte reads 00h, `so_oe` is low, and array byte i holds the value i (low 8 bits of the index).
- R2: Write enable (opcode 06h) sets the latch in status bit 1 only when chip select rises after exactly 8 bits. 7 or 9 bits leave it clear.
- R3: Erase (opcode D8h, then 24 address bits, MSB first) with the latch set and an unprotected sector sets every byte of that sector to FFh and changes no other byte. The low address bits do not matter.
- R4: An erase whose chip select rises after 31 or 33 bits is discarded. No byte changes, status bit 0 stays 0 and the latch stays set.
- R5: An erase sent without a prior write enable changes nothing.
- R6: The busy flag (status bit 0) reads 1 from the chip-select rise that starts an accepted erase until the erase ends. Bytes keep their old values while it is 1. Busy and the latch are both 0 afterwards.
- R7: Protection (status bits 3:2): 00 protects nothing, 01 protects sector 3, 10 protects sectors 2 and 3, 11 protects all. An erase of a protected sector changes no byte and clears the latch.
- R8: While busy is 1, write-enable and erase commands are ignored.
- R9: Read status (opcode 05h) returns the status byte MSB first after the opcode, repeated for each further byte, with bits 7:4 zero. It is snapshotted at each byte start. `so_oe` is high only in that data phase, and never during erase or write-enable transactions.
- R10: The sector is address bits 23:22. Array index is {addr[23:22], addr[ARR_AW-3:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial pins are oversampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, sampled on rising sck |
| so | output | 1 | Serial data out, changes after falling sck |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| bp_load | input | 1 | Loads `bp_value` into the protection field |
| bp_value | input | 2 | New protection field value |
| rd_idx | input | ARR_AW | Side read index into the array |
| rd_data | output | DW | Array byte at `rd_idx` |

## Verification
Completion of the self-timed erase can land inside a status-read transaction, so the busy and latch bits change while the host is shifting status bytes out. The bench starts an erase and at once issues a status read long enough to span the whole erase window. It judges each returned byte to be either the complete busy value 03h or the complete idle value 00h, with no idle byte followed by a busy one and the last byte idle. A second erase command sent during the busy window checks that erase launch and rejection never overlap.

// File: rtl/sector_erase_pkg.sv
package sector_erase_pkg;

   localparam logic [7:0] OP_WR_ENABLE = 8'h06;
   localparam logic [7:0] OP_SECT_ERASE = 8'h D8;
   localparam logic [7:0] OP_READ_STAT = 8'h05;

   // true when the guard field covers the given quarter of the array
   function automatic logic sector_locked(input logic [1:0] guard, input logic [1:0] sect);
      case (guard)
         2'b00:   return 1'b0;
         2'b01:   return sect == 2'b11;
         2'b10:   return sect[1];
         default: return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/spi_cmd_front.sv
module spi_cmd_front
   import sector_erase_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       si,
   input  logic [7:0] status_byte,
   output logic       so,
   output logic       so_oe,
   output logic       ev_valid,
   output logic [7:0] ev_op,
   output logic [2:0] ev_nbytes,
   output logic [2:0] ev_bcnt,
   output logic [1:0] ev_sect
);

   logic       sck_r, sck_rr, cs_r, cs_rr, si_r;
   logic       sck_rise, sck_fall;
   logic [6:0] sh;
   logic [2:0] bcnt;
   logic [2:0] nbytes;
   logic [7:0] op;
   logic [1:0] sect;
   logic [7:0] obuf;
   logic       rd_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_r  <= 1'b0;
         sck_rr <= 1'b0;
         cs_r   <= 1'b1;
         cs_rr  <= 1'b1;
         si_r   <= 1'b0;
      end else begin
         sck_r  <= sck;
         sck_rr <= sck_r;
         cs_r   <= cs_n;
         cs_rr  <= cs_r;
         si_r   <= si;
      end
   end

   assign sck_rise = sck_r & ~sck_rr & ~cs_r;
   assign sck_fall = ~sck_r & sck_rr & ~cs_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         bcnt   <= '0;
         nbytes <= '0;
         op     <= '0;
         sect   <= '0;
      end else if (cs_r) begin
         bcnt   <= '0;
         nbytes <= '0;
         op     <= '0;
      end else if (sck_rise) begin
         sh   <= {sh[5:0], si_r};
         bcnt <= bcnt + 3'd1;
         if (bcnt == 3'd7 && nbytes != 3'd7)
            nbytes <= nbytes + 3'd1;
         if (bcnt == 3'd7 && nbytes == 3'd0)
            op <= {sh, si_r};
         if (bcnt == 3'd1 && nbytes == 3'd1)
            sect <= {sh[0], si_r};
      end
   end

   assign rd_mode = (op == OP_READ_STAT) && (nbytes != 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         obuf <= '0;
      else if (cs_r)
         obuf <= '0;
      else if (sck_fall && rd_mode) begin
         if (bcnt == 3'd0)
            obuf <= status_byte;
         else
            obuf <= {obuf[6:0], 1'b0};
      end
   end

   assign so        = obuf[7];
   assign so_oe     = rd_mode & ~cs_r;
   assign ev_valid  = cs_r & ~cs_rr;
   assign ev_op     = op;
   assign ev_nbytes = nbytes;
   assign ev_bcnt   = bcnt;
   assign ev_sect   = sect;

   // R9
   out_quiet_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n)) |-> !so_oe);

   // R4
   count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_r && !cs_n && sck_r == sck_rr) |=> $stable(bcnt) && $stable(nbytes));

endmodule

// File: rtl/erase_status_ctl.sv
module erase_status_ctl
   import sector_erase_pkg::*;
#(
   parameter int ERASE_CYC = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_valid,
   input  logic [7:0] ev_op,
   input  logic [2:0] ev_nbytes,
   input  logic [2:0] ev_bcnt,
   input  logic [1:0] ev_sect,
   input  logic       bp_load,
   input  logic [1:0] bp_value,
   output logic [7:0] status_byte,
   output logic       erase_go,
   output logic [1:0] erase_sect
);

   localparam int TW = (ERASE_CYC > 1) ? $clog2(ERASE_CYC) : 1;

   logic          wip, wel;
   logic [1:0]    bp;
   logic [TW-1:0] tmr;
   logic [1:0]    sect_q;
   logic          len_wren_ok, len_erase_ok;

   assign len_wren_ok  = (ev_nbytes == 3'd1) && (ev_bcnt == 3'd0);
   assign len_erase_ok = (ev_nbytes == 3'd4) && (ev_bcnt == 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bp <= '0;
      else if (bp_load)
         bp <= bp_value;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip    <= 1'b0;
         wel    <= 1'b0;
         tmr    <= '0;
         sect_q <= '0;
      end else if (wip) begin
         if (tmr == '0) begin
            wip <= 1'b0;
            wel <= 1'b0;
         end else
            tmr <= tmr - 1'b1;
      end else if (ev_valid) begin
         if (ev_op == OP_WR_ENABLE && len_wren_ok)
            wel <= 1'b1;
         else if (ev_op == OP_SECT_ERASE && len_erase_ok && wel) begin
            if (sector_locked(bp, ev_sect))
               wel <= 1'b0;
            else begin
               wip    <= 1'b1;
               tmr    <= TW'(ERASE_CYC - 1);
               sect_q <= ev_sect;
            end
         end
      end
   end

   assign erase_go    = wip && (tmr == '0);
   assign erase_sect  = sect_q;
   assign status_byte = {4'b0000, bp, wel, wip};

   // R6
   latch_set_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> wel);

   // R6
   latch_clear_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |-> !wel);

   // R8
   busy_target_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && !erase_go) |=> wip && $stable(sect_q));

   // R7
   locked_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wip && ev_valid && ev_op == OP_SECT_ERASE && sector_locked(bp, ev_sect)) |=> !wip);

endmodule

// File: rtl/sector_regfile.sv
module sector_regfile #(
   parameter int ARR_AW = 6,
   parameter int DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_go,
   input  logic [1:0]        erase_sect,
   input  logic [ARR_AW-1:0] rd_idx,
   output logic [DW-1:0]     rd_data
);

   localparam int NBYTES = 1 << ARR_AW;
   localparam int SEC_SH = ARR_AW - 2;

   if (ARR_AW < 3 || ARR_AW > 10) begin : g_bad_aw
      $error("sector_regfile: ARR_AW out of range");
   end

   logic [DW-1:0] mem [NBYTES];

   for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      localparam logic [1:0] MY_SEC = 2'(i >> SEC_SH);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= DW'(i);
         else if (erase_go && erase_sect == MY_SEC)
            mem[i] <= '1;
      end

      // R3
      erased_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (erase_go && erase_sect == MY_SEC) |=> mem[i] == '1);

      // R6
      kept_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !erase_go |=> $stable(mem[i]));
   end

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/spi_sector_erase_engine.sv
module spi_sector_erase_engine #(
   parameter int ARR_AW    = 6,
   parameter int DW        = 8,
   parameter int ERASE_CYC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   output logic              so,
   output logic              so_oe,
   input  logic              bp_load,
   input  logic [1:0]        bp_value,
   input  logic [ARR_AW-1:0] rd_idx,
   output logic [DW-1:0]     rd_data
);

   if (DW != 8) begin : g_bad_dw
      $error("spi_sector_erase_engine: DW must be 8");
   end
   if (ERASE_CYC < 1) begin : g_bad_cyc
      $error("spi_sector_erase_engine: ERASE_CYC must be positive");
   end

   logic [7:0] status_byte;
   logic       ev_valid;
   logic [7:0] ev_op;
   logic [2:0] ev_nbytes, ev_bcnt;
   logic [1:0] ev_sect;
   logic       erase_go;
   logic [1:0] erase_sect;

   spi_cmd_front i_front (
      .clk, .rst_n, .cs_n, .sck, .si, .status_byte,
      .so, .so_oe, .ev_valid, .ev_op, .ev_nbytes, .ev_bcnt, .ev_sect
   );

   erase_status_ctl #(.ERASE_CYC(ERASE_CYC)) i_ctl (
      .clk, .rst_n, .ev_valid, .ev_op, .ev_nbytes, .ev_bcnt, .ev_sect,
      .bp_load, .bp_value, .status_byte, .erase_go, .erase_sect
   );

   sector_regfile #(.ARR_AW(ARR_AW), .DW(DW)) i_array (
      .clk, .rst_n, .erase_go, .erase_sect, .rd_idx, .rd_data
   );

endmodule

// File: tb/test_spi_sector_erase_engine.sv
module test_spi_sector_erase_engine;

   localparam int AW = 6;
   localparam int NB = 1 << AW;
   localparam int ECYC = 1000;
   localparam int HB = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic so, so_oe;
   logic bp_load = 1'b0;
   logic [1:0] bp_value = '0;
   logic [AW-1:0] rd_idx = '0;
   logic [7:0] rd_data;

   int total = 0, bad = 0;
   bit done = 0;
   logic [7:0] model [NB];
   logic [7:0] rbuf [16];
   int oe_seen;

   always #2 clk = ~clk;

   spi_sector_erase_engine #(.ARR_AW(AW), .DW(8), .ERASE_CYC(ECYC)) i_spi_sector_erase_engine (
      .clk, .rst_n, .cs_n, .sck, .si, .so, .so_oe,
      .bp_load, .bp_value, .rd_idx, .rd_data
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic spi_send(input int nbits, input logic [39:0] val);
      cs_n = 1'b0;
      tick(4);
      for (int b = nbits - 1; b >= 0; b--) begin
         si = val[b];
         sck = 1'b0;
         tick(HB);
         if (so_oe) oe_seen++;
         sck = 1'b1;
         tick(HB);
      end
      sck = 1'b0;
      tick(HB);
      cs_n = 1'b1;
      tick(HB);
   endtask

   task automatic rdsr(input int nbytes);
      int low_oe = 0;
      cs_n = 1'b0;
      tick(4);
      for (int b = 7; b >= 0; b--) begin
         si = b[0] ? 1'b0 : 1'b0;
         si = (8'h05 >> b) & 1;
         sck = 1'b0;
         tick(HB);
         sck = 1'b1;
         tick(HB);
      end
      for (int k = 0; k < nbytes; k++) begin
         for (int b = 7; b >= 0; b--) begin
            sck = 1'b0;
            tick(HB);
            rbuf[k][b] = so;
            if (!so_oe) low_oe++;
            sck = 1'b1;
            tick(HB);
         end
      end
      sck = 1'b0;
      tick(HB);
      cs_n = 1'b1;
      tick(HB);
      check("R9 so_oe low during status data", low_oe, 0);
   endtask

   task automatic check_array(input string req);
      int miss = 0;
      for (int i = 0; i < NB; i++) begin
         rd_idx = AW'(i);
         #1;
         if (rd_data !== model[i]) miss++;
      end
      check(req, miss, 0);
   endtask

   function automatic logic locked(input int bp, input int s);
      int q = (bp == 3) ? 4 : bp;
      return s >= 4 - q;
   endfunction

   function automatic logic [23:0] addr_of(input int s, input int low);
      return {2'(s), 22'(low)};
   endfunction

   task automatic wren();
      spi_send(8, 40'h06);
   endtask

   task automatic erase_cmd(input logic [23:0] a);
      spi_send(32, {8'h00, 8'hD8, a});
   endtask

   task automatic model_erase(input int s);
      for (int i = 0; i < NB; i++)
         if ((i >> (AW - 2)) == s) model[i] = 8'hFF;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NB; i++) model[i] = 8'(i);
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R1 reset state
      check("R1 so_oe after reset", so_oe, 0);
      check_array("R1 array reset pattern");
      rdsr(1);
      check("R1 status after reset", rbuf[0], 8'h00);

      // R5 erase without write enable
      oe_seen = 0;
      erase_cmd(addr_of(0, 5));
      tick(ECYC + 100);
      check_array("R5 no change without latch");
      rdsr(1);
      check("R5 status idle", rbuf[0], 8'h00);

      // R2 write-enable length
      spi_send(7, 40'h03);
      rdsr(1);
      check("R2 7-bit write enable ignored", rbuf[0], 8'h00);
      spi_send(9, 40'h0C);
      rdsr(1);
      check("R2 9-bit write enable ignored", rbuf[0], 8'h00);
      wren();
      rdsr(1);
      check("R2 8-bit write enable sets latch", rbuf[0], 8'h02);

      // R4 discarded erase on wrong length
      spi_send(31, {8'h00, 8'hD8, addr_of(0, 7)} >> 1);
      tick(ECYC + 100);
      check_array("R4 31-bit erase discarded");
      rdsr(1);
      check("R4 status after 31 bits", rbuf[0], 8'h02);
      spi_send(33, {7'h00, 8'hD8, addr_of(0, 7), 1'b1});
      tick(ECYC + 100);
      check_array("R4 33-bit erase discarded");
      rdsr(1);
      check("R4 status after 33 bits", rbuf[0], 8'h02);
      check("R9 so_oe low in erase and enable", oe_seen, 0);

      // R6 R8 R3 R10 accepted erase of sector 1 with completion during a status poll
      erase_cmd(addr_of(1, 22'h2A5C3));
      check_array("R6 bytes unchanged while busy");
      erase_cmd(addr_of(2, 3));
      rdsr(12);
      begin
         int order_err = 0;
         int shape_err = 0;
         bit seen_idle = 0;
         for (int k = 0; k < 12; k++) begin
            if (rbuf[k] != 8'h03 && rbuf[k] != 8'h00) shape_err++;
            if (rbuf[k] == 8'h00) seen_idle = 1;
            else if (seen_idle) order_err++;
         end
         check("R6 first poll byte busy", rbuf[0], 8'h03);
         check("R9 poll bytes whole snapshots", shape_err, 0);
         check("R6 busy never returns", order_err, 0);
         check("R6 last poll byte idle", rbuf[11], 8'h00);
      end
      model_erase(1);
      check_array("R3 R8 R10 sector 1 erased, sector 2 kept");
      rdsr(1);
      check("R6 latch clear after erase", rbuf[0], 8'h00);

      // R7 R3 R10 sweep of guard settings and sectors
      for (int bp = 3; bp >= 0; bp--) begin
         @(negedge clk);
         bp_value = 2'(bp);
         bp_load = 1'b1;
         @(negedge clk);
         bp_load = 1'b0;
         for (int s = 0; s < 4; s++) begin
            wren();
            erase_cmd(addr_of(s, (s * 22'h13579 + bp * 22'h0BEEF) & 22'h3FFFFF));
            tick(ECYC + 100);
            if (!locked(bp, s)) model_erase(s);
            check_array($sformatf("R7 R3 guard=%0d sector=%0d array", bp, s));
            rdsr(1);
            check($sformatf("R7 guard=%0d sector=%0d status", bp, s), rbuf[0], {4'h0, 2'(bp), 2'b00});
         end
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule